// File: doc/BRIEF.md
# Instruction Control Decoder

This block turns the operation code and function code of a fetched instruction into the control signals that steer a single-cycle datapath. These signals are the register-file write enable, the choice of destination register field, the choice of the second ALU operand, the branch and jump requests, the data-memory write enable, the writeback source, and a 3-bit ALU operation select.

The decode runs in two levels. A primary decoder looks only at the operation code. It produces the datapath controls and a 2-bit intermediate ALU class. A secondary decoder turns that class into the ALU select, and it reads the function code only when the class says to. The results are captured in an output register that is cleared by a synchronous active-high reset. The controls for an instruction therefore appear one clock after its codes are presented.

Top module: `ctrl_decode`

## Requirements
- R1: While `rst` is high at a rising edge, every output is 0 after that edge.
- R2: Outputs change only at a rising clock edge. After each edge they reflect the `opcode` and `funct` values sampled at that edge.
- R3: Opcode 000000 with a recognised function code gives reg_wr=1, dst_rd=1, src_imm=0, branch=0, mem_wr=0, mem_to_reg=0, jump=0.
- R4: Opcode 100011 (load word) gives reg_wr=1, dst_rd=0, src_imm=1, branch=0, mem_wr=0, mem_to_reg=1, jump=0, alu_ctl=010.
- R5: Opcode 101011 (store word) gives mem_wr=1, src_imm=1, alu_ctl=010, and 0 on every other output. This includes the two don't-care fields, dst_rd and mem_to_reg.
- R6: Opcode 000100 (branch if equal) gives branch=1, alu_ctl=110 (subtract), and 0 on every other output.
- R7: Opcode 001000 (add immediate) gives reg_wr=1, src_imm=1, alu_ctl=010, and 0 on every other output.
- R8: Opcode 000010 (jump) gives jump=1, alu_ctl=010, and 0 on every other output. No other opcode ever sets jump.
- R9: For opcode 000000, the function code selects alu_ctl as follows: 100000 gives 010 (add), 100010 gives 110 (subtract), 100100 gives 000 (and), 100101 gives 001 (or), 101010 gives 111 (set-less-than).
- R10: For opcode 000000 with any other function code, reg_wr=0, mem_wr=0 and alu_ctl=000. dst_rd stays 1.
- R11: Any opcode not listed above drives every output to 0, whatever the function code.
- R12: For every opcode other than 000000, the function code has no effect on any output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| opcode | input | 6 | Operation code field of the instruction |
| funct | input | 6 | Function code field of the instruction |
| reg_wr | output | 1 | Register file write enable |
| dst_rd | output | 1 | 1 selects the rd field as destination, 0 selects rt |
| src_imm | output | 1 | 1 selects the sign-extended immediate as second ALU operand |
| branch | output | 1 | Conditional branch request |
| mem_wr | output | 1 | Data memory write enable |
| mem_to_reg | output | 1 | 1 writes memory read data back, 0 writes the ALU result |
| jump | output | 1 | Unconditional jump request |
| alu_ctl | output | 3 | ALU operation select |

## Verification
Each of the six known opcodes is applied with a neutral function code, and the full output vector is compared. This separates the instruction classes and exposes any wrong value in a don't-care field. The five register-format function codes are then applied one after another, which separates the five ALU selects from one another. An unknown function code and an unknown opcode are applied next; these show that the write enables are suppressed instead of falling into a default entry. Last, load word and branch are repeated with function codes that would mean subtract or or-combine. This shows that the function code is ignored outside the register format. The held value between edges shows the one-cycle latency.

// File: rtl/ctrl_decode_pkg.sv
package ctrl_decode_pkg;
  parameter int OP_W   = 6;
  parameter int FN_W   = 6;
  parameter int ALUC_W = 3;
  parameter int CLS_W  = 2;

  typedef enum logic [OP_W-1:0] {
    OPC_REG  = 6'b000000,
    OPC_JMP  = 6'b000010,
    OPC_BEQ  = 6'b000100,
    OPC_ADDI = 6'b001000,
    OPC_LOAD = 6'b100011,
    OPC_STOR = 6'b101011
  } opc_e;

  typedef enum logic [CLS_W-1:0] {
    CLS_ADD   = 2'b00,
    CLS_SUB   = 2'b01,
    CLS_FIELD = 2'b10,
    CLS_SUB2  = 2'b11
  } alu_cls_e;

  typedef enum logic [ALUC_W-1:0] {
    AC_AND = 3'b000,
    AC_OR  = 3'b001,
    AC_ADD = 3'b010,
    AC_SUB = 3'b110,
    AC_SLT = 3'b111
  } alu_ctl_e;

  typedef enum logic [FN_W-1:0] {
    FN_ADD = 6'b100000,
    FN_SUB = 6'b100010,
    FN_AND = 6'b100100,
    FN_OR  = 6'b100101,
    FN_SLT = 6'b101010
  } fn_e;

  typedef struct packed {
    logic     reg_wr;
    logic     dst_rd;
    logic     src_imm;
    logic     branch;
    logic     mem_wr;
    logic     mem_to_reg;
    logic     jump;
    alu_cls_e cls;
  } main_ctl_t;
endpackage

// File: rtl/ctrl_main_dec.sv
module ctrl_main_dec
  import ctrl_decode_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output main_ctl_t       ctl,
  output logic            op_ok
);
  always_comb begin
    ctl   = '0;
    op_ok = 1'b1;
    case (opcode)
      OPC_REG: begin
        ctl.reg_wr = 1'b1;
        ctl.dst_rd = 1'b1;
        ctl.cls    = CLS_FIELD;
      end
      OPC_LOAD: begin
        ctl.reg_wr     = 1'b1;
        ctl.src_imm    = 1'b1;
        ctl.mem_to_reg = 1'b1;
      end
      OPC_STOR: begin
        ctl.src_imm = 1'b1;
        ctl.mem_wr  = 1'b1;
      end
      OPC_BEQ: begin
        ctl.branch = 1'b1;
        ctl.cls    = CLS_SUB;
      end
      OPC_ADDI: begin
        ctl.reg_wr  = 1'b1;
        ctl.src_imm = 1'b1;
      end
      OPC_JMP: begin
        ctl.jump = 1'b1;
      end
      default: op_ok = 1'b0;
    endcase
  end
endmodule

// File: rtl/ctrl_alu_dec.sv
module ctrl_alu_dec
  import ctrl_decode_pkg::*;
(
  input  alu_cls_e          cls,
  input  logic [FN_W-1:0]   funct,
  output logic [ALUC_W-1:0] alu_ctl,
  output logic              fn_ok
);
  always_comb begin
    fn_ok   = 1'b1;
    alu_ctl = AC_ADD;
    if (cls[0]) begin
      alu_ctl = AC_SUB;
    end else if (cls[1]) begin
      case (funct)
        FN_ADD:  alu_ctl = AC_ADD;
        FN_SUB:  alu_ctl = AC_SUB;
        FN_AND:  alu_ctl = AC_AND;
        FN_OR:   alu_ctl = AC_OR;
        FN_SLT:  alu_ctl = AC_SLT;
        default: begin
          alu_ctl = AC_AND;
          fn_ok   = 1'b0;
        end
      endcase
    end
  end
endmodule

// File: rtl/ctrl_decode.sv
module ctrl_decode
  import ctrl_decode_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic [OP_W-1:0]   opcode,
  input  logic [FN_W-1:0]   funct,
  output logic              reg_wr,
  output logic              dst_rd,
  output logic              src_imm,
  output logic              branch,
  output logic              mem_wr,
  output logic              mem_to_reg,
  output logic              jump,
  output logic [ALUC_W-1:0] alu_ctl
);
  main_ctl_t         mctl;
  logic              op_ok;
  logic [ALUC_W-1:0] actl;
  logic              fn_ok;

  ctrl_main_dec u_main (
    .opcode (opcode),
    .ctl    (mctl),
    .op_ok  (op_ok)
  );

  ctrl_alu_dec u_alu (
    .cls     (mctl.cls),
    .funct   (funct),
    .alu_ctl (actl),
    .fn_ok   (fn_ok)
  );

  main_ctl_t         nxt;
  logic [ALUC_W-1:0] nxt_alu;

  always_comb begin
    nxt     = mctl;
    nxt_alu = actl;
    if (!fn_ok) nxt.reg_wr = 1'b0;
    if (!op_ok) begin
      nxt     = '0;
      nxt_alu = '0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      reg_wr     <= 1'b0;
      dst_rd     <= 1'b0;
      src_imm    <= 1'b0;
      branch     <= 1'b0;
      mem_wr     <= 1'b0;
      mem_to_reg <= 1'b0;
      jump       <= 1'b0;
      alu_ctl    <= '0;
    end else begin
      reg_wr     <= nxt.reg_wr;
      dst_rd     <= nxt.dst_rd;
      src_imm    <= nxt.src_imm;
      branch     <= nxt.branch;
      mem_wr     <= nxt.mem_wr;
      mem_to_reg <= nxt.mem_to_reg;
      jump       <= nxt.jump;
      alu_ctl    <= nxt_alu;
    end
  end
endmodule

// File: rtl/ctrl_decode_chk.sv
module ctrl_decode_chk
  import ctrl_decode_pkg::*;
(
  input logic              clk,
  input logic              rst,
  input logic [OP_W-1:0]   opcode,
  input logic [FN_W-1:0]   funct,
  input logic              reg_wr,
  input logic              dst_rd,
  input logic              src_imm,
  input logic              branch,
  input logic              mem_wr,
  input logic              mem_to_reg,
  input logic              jump,
  input logic [ALUC_W-1:0] alu_ctl
);
  logic rst_q;
  logic live;
  logic [OP_W-1:0] op_q;
  logic known_q;

  always_ff @(posedge clk) begin
    rst_q   <= rst;
    live    <= !rst;
    op_q    <= opcode;
    known_q <= (opcode == OPC_REG) || (opcode == OPC_JMP) || (opcode == OPC_BEQ) ||
               (opcode == OPC_ADDI) || (opcode == OPC_LOAD) || (opcode == OPC_STOR);
  end

  always_ff @(posedge clk) begin
    if (rst_q === 1'b1)
      AST_RESET_ZERO: assert ({reg_wr, dst_rd, src_imm, branch, mem_wr, mem_to_reg, jump, alu_ctl} == '0); // R1
  end

  AST_JUMP_ONLY_J: assert property (@(posedge clk) disable iff (rst)
    (live === 1'b1) && (op_q != OPC_JMP) |-> !jump); // R8

  AST_JUMP_SET: assert property (@(posedge clk) disable iff (rst)
    (live === 1'b1) && (op_q == OPC_JMP) |-> jump && !reg_wr && !mem_wr); // R8

  AST_BEQ_SUB: assert property (@(posedge clk) disable iff (rst)
    (live === 1'b1) && (op_q == OPC_BEQ) |-> branch && (alu_ctl == AC_SUB) && !reg_wr); // R6

  AST_LOAD_CTL: assert property (@(posedge clk) disable iff (rst)
    (live === 1'b1) && (op_q == OPC_LOAD) |-> reg_wr && src_imm && mem_to_reg && (alu_ctl == AC_ADD)); // R4

  AST_UNKNOWN_OP: assert property (@(posedge clk) disable iff (rst)
    (live === 1'b1) && (known_q === 1'b0) |->
      ({reg_wr, dst_rd, src_imm, branch, mem_wr, mem_to_reg, jump, alu_ctl} == '0)); // R11
endmodule

bind ctrl_decode ctrl_decode_chk u_chk (
  .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
  .reg_wr(reg_wr), .dst_rd(dst_rd), .src_imm(src_imm), .branch(branch),
  .mem_wr(mem_wr), .mem_to_reg(mem_to_reg), .jump(jump), .alu_ctl(alu_ctl)
);

// File: tb/ctrl_decode_tb.sv
module ctrl_decode_tb;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic [5:0] opcode = '0;
  logic [5:0] funct  = '0;
  logic reg_wr, dst_rd, src_imm, branch, mem_wr, mem_to_reg, jump;
  logic [2:0] alu_ctl;
  int n_run  = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  ctrl_decode u_dut (
    .clk(clk), .rst(rst), .opcode(opcode), .funct(funct),
    .reg_wr(reg_wr), .dst_rd(dst_rd), .src_imm(src_imm), .branch(branch),
    .mem_wr(mem_wr), .mem_to_reg(mem_to_reg), .jump(jump), .alu_ctl(alu_ctl)
  );

  // packed order: reg_wr dst_rd src_imm branch mem_wr mem_to_reg jump alu_ctl[2:0]
  function automatic logic [9:0] outs();
    return {reg_wr, dst_rd, src_imm, branch, mem_wr, mem_to_reg, jump, alu_ctl};
  endfunction

  task automatic check(input string tag, input logic [9:0] exp);
    n_run++;
    if (outs() !== exp) begin
      n_fail++;
      $display("FAIL %s: got %b expected %b", tag, outs(), exp);
    end
  endtask

  // apply at negedge, let one rising edge pass, compare at next negedge
  task automatic apply(input logic [5:0] op, input logic [5:0] fn,
                       input string tag, input logic [9:0] exp);
    @(negedge clk);
    opcode = op;
    funct  = fn;
    @(negedge clk);
    check(tag, exp);
  endtask

  task automatic t_reset();
    rst = 1'b1; opcode = 6'b000010; funct = 6'b0;
    @(negedge clk); @(negedge clk);
    check("R1 reset clears", 10'b0000000_000);
    rst = 1'b0;
  endtask

  task automatic t_rtype();
    apply(6'b000000, 6'b100000, "R3 R9 add", 10'b1100000_010);
    apply(6'b000000, 6'b100010, "R9 sub",    10'b1100000_110);
    apply(6'b000000, 6'b100100, "R9 and",    10'b1100000_000);
    apply(6'b000000, 6'b100101, "R9 or",     10'b1100000_001);
    apply(6'b000000, 6'b101010, "R3 R9 slt", 10'b1100000_111);
  endtask

  task automatic t_mem();
    apply(6'b100011, 6'b000000, "R4 load",  10'b1010010_010);
    apply(6'b101011, 6'b000000, "R5 store", 10'b0010100_010);
  endtask

  task automatic t_flow();
    apply(6'b000100, 6'b000000, "R6 beq",  10'b0001000_110);
    apply(6'b001000, 6'b000000, "R7 addi", 10'b1010000_010);
    apply(6'b000010, 6'b000000, "R8 jump", 10'b0000001_010);
  endtask

  task automatic t_bad();
    apply(6'b000000, 6'b111111, "R10 bad funct", 10'b0100000_000);
    apply(6'b111111, 6'b100000, "R11 bad op a",  10'b0000000_000);
    apply(6'b000011, 6'b101010, "R11 bad op b",  10'b0000000_000);
  endtask

  task automatic t_funct_ignored();
    apply(6'b100011, 6'b100010, "R12 load funct sub", 10'b1010010_010);
    apply(6'b000100, 6'b100101, "R12 beq funct or",   10'b0001000_110);
    apply(6'b000010, 6'b101010, "R12 R8 jump funct",  10'b0000001_010);
  endtask

  task automatic t_latency();
    apply(6'b101011, 6'b000000, "R2 setup store", 10'b0010100_010);
    @(negedge clk);
    opcode = 6'b000100;
    #2;
    check("R2 holds before edge", 10'b0010100_010);
    @(posedge clk); #1;
    check("R2 updates after edge", 10'b0001000_110);
  endtask

  initial begin
    t_reset();
    t_rtype();
    t_mem();
    t_flow();
    t_bad();
    t_funct_ignored();
    t_latency();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    #100000;
    n_run++;
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule